// File: doc/BRIEF.md
# I2C Event Interrupt Status and Vector Unit

This unit sits beside an I2C controller and turns the single-cycle event pulses the controller raises into sticky status flags. There are seven events: arbitration lost, not-acknowledged, access ready, receive ready, transmit ready, stop detected and addressed-as-slave. Each flag is gated by its own enable bit in a mask register. The unit drives one interrupt line that is high whenever an enabled flag is pending.

Software services the unit through a small register port with three registers: mask, status and vector. Reading the vector register returns a 3-bit code for the most urgent pending enabled event. The same read acknowledges that event, so a handler can loop on the vector until it reads zero. Status flags are cleared by writing ones to them. The receive-ready and transmit-ready flags are not cleared by the vector read. They stay set until the data path signals that the data register was accessed. The status register also mirrors two live bus conditions: bus busy and receive shift register full.

Top module: `evt_irq_unit`

## Requirements
- R1: After synchronous reset, all flags, the mask, `irq_o` and `rdata_o` are zero.
- R2: An `evt_i[i]` pulse sets status bit i (i = 0..6) at the next clock edge. The bits are: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. Status is read at byte offset 0x08.
- R3: Writing status with a 1 in bit i (i = 0..6) clears flag i. A 0 leaves the flag unchanged.
- R4: An event that arrives in the same cycle as any clear of its flag wins, and the flag stays set.
- R5: A read at offset 0x28 returns, in bits 2:0, code i+1 of the lowest-indexed flag i that is both set and enabled. It returns 0 when no enabled flag is set. Bits 15:3 read 0.
- R6: A vector read clears the flag it reports, except receive ready (code 4) and transmit ready (code 5).
- R7: A `rx_data_acc_i` pulse clears the receive-ready flag. A `tx_data_acc_i` pulse clears the transmit-ready flag.
- R8: `irq_o` equals the OR of (flag AND mask) over all seven events, and changes in the same cycle as the flags.
- R9: Status bit 12 shows `bus_busy_i` and bit 11 shows `rx_shift_full_i`, each registered once. Writes to the status register never change them.
- R10: The mask register at offset 0x04 holds bit i as the enable for event i (i = 0..6). Its upper bits read 0.
- R11: Read data is registered: `rdata_o` updates at the edge that samples `rd_en_i`, holds the state from before that edge, and otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Event pulses, index as in R2 |
| rx_data_acc_i | input | 1 | Receive data register was read |
| tx_data_acc_i | input | 1 | Transmit data register was written |
| bus_busy_i | input | 1 | Bus busy level |
| rx_shift_full_i | input | 1 | Receive shift register full level |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: 16-bit data, 8-bit byte offsets and the 0x04/0x08/0x28 offsets. With these, every register, the bit positions 11 and 12 and an unmapped offset are all reachable within a short random run. Mixed random reads, writes and sparse event bursts drive multi-flag priority orders and same-cycle set/clear collisions. Directed sequences cover the vector service loop, including the receive-ready flag that survives a vector read.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_EVT   = 7;
  localparam int CODE_W    = 3;
  localparam int IDX_RXRDY = 3;
  localparam int IDX_TXRDY = 4;
  localparam int BIT_RSF   = 11;
  localparam int BIT_BUSY  = 12;

  typedef enum logic [CODE_W-1:0] {
    VEC_NONE  = 3'd0,
    VEC_ARB   = 3'd1,
    VEC_NACK  = 3'd2,
    VEC_ARDY  = 3'd3,
    VEC_RXRDY = 3'd4,
    VEC_TXRDY = 3'd5,
    VEC_STOP  = 3'd6,
    VEC_SLAVE = 3'd7
  } vec_code_e;
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
  parameter int N  = 7,
  parameter int CW = 3
) (
  input  logic [N-1:0]  pend_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    assign nxt_o[g] = set_i[g] | (q_o[g] & ~clr_i[g]);
    always_ff @(posedge clk) begin
      if (rst) q_o[g] <= 1'b0;
      else     q_o[g] <= nxt_o[g];
    end
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h04,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h08,
  parameter logic [ADDR_W-1:0] OFS_VEC  = 8'h28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               rx_data_acc_i,
  input  logic               tx_data_acc_i,
  input  logic               bus_busy_i,
  input  logic               rx_shift_full_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flag_q, flag_nxt, mask_q, mask_nxt, clr;
  logic [CODE_W-1:0]  code;
  logic               busy_q, rsf_q;
  logic               hit_mask, hit_stat, hit_vec, vec_rd;
  logic [DATA_W-1:0]  stat_word;
  logic               unused_hi;

  assign hit_mask  = (addr_i == OFS_MASK);
  assign hit_stat  = (addr_i == OFS_STAT);
  assign hit_vec   = (addr_i == OFS_VEC);
  assign vec_rd    = rd_en_i & hit_vec;
  assign unused_hi = ^wdata_i[DATA_W-1:NUM_EVT];

  evt_prio_enc #(.N(NUM_EVT), .CW(CODE_W)) u_enc (
    .pend_i (flag_q & mask_q),
    .code_o (code)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_clr
    logic ack_ok, data_acc;
    if (g == IDX_RXRDY) begin : g_rx
      assign ack_ok   = 1'b0;
      assign data_acc = rx_data_acc_i;
    end else if (g == IDX_TXRDY) begin : g_tx
      assign ack_ok   = 1'b0;
      assign data_acc = tx_data_acc_i;
    end else begin : g_oth
      assign ack_ok   = 1'b1;
      assign data_acc = 1'b0;
    end
    assign clr[g] = (wr_en_i & hit_stat & wdata_i[g])
                  | (vec_rd & ack_ok & (code == CODE_W'(g + 1)))
                  | data_acc;
  end

  evt_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (evt_i),
    .clr_i (clr),
    .q_o   (flag_q),
    .nxt_o (flag_nxt)
  );

  assign mask_nxt = (wr_en_i & hit_mask) ? wdata_i[NUM_EVT-1:0] : mask_q;

  always_comb begin
    stat_word                    = '0;
    stat_word[NUM_EVT-1:0]       = flag_q;
    stat_word[BIT_RSF]           = rsf_q;
    stat_word[BIT_BUSY]          = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      irq_o   <= 1'b0;
      busy_q  <= 1'b0;
      rsf_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      mask_q <= mask_nxt;
      irq_o  <= |(flag_nxt & mask_nxt);
      busy_q <= bus_busy_i;
      rsf_q  <= rx_shift_full_i;
      if (rd_en_i) begin
        if (hit_mask)      rdata_o <= DATA_W'(mask_q);
        else if (hit_stat) rdata_o <= stat_word;
        else if (hit_vec)  rdata_o <= DATA_W'(code);
        else               rdata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h04,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h08,
  parameter logic [ADDR_W-1:0] OFS_VEC  = 8'h28
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_EVT-1:0] wdata_lo,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] flag_q,
  input logic [NUM_EVT-1:0] mask_q
);
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flag_q & mask_q)); // R8

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == OFS_STAT) |=> ((flag_q & $past(wdata_lo) & ~$past(evt_i)) == '0)); // R3

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == OFS_VEC) |=> (rdata_o[DATA_W-1:CODE_W] == '0)); // R5

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == OFS_MASK) |=> (mask_q == $past(wdata_lo))); // R10
endmodule

bind evt_irq_unit evt_irq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .OFS_MASK(OFS_MASK), .OFS_STAT(OFS_STAT), .OFS_VEC(OFS_VEC)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_lo(wdata_i[evt_pkg::NUM_EVT-1:0]), .rdata_o(rdata_o),
  .irq_o(irq_o), .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/evt_irq_unit_tb.sv
module evt_irq_unit_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic [6:0]  evt = '0;
  logic        rxacc = 0, txacc = 0, busy = 0, rsf = 0, wr = 0, rd = 0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;
  int          total = 0, bad = 0;

  logic [6:0]  m_flags = '0, m_mask = '0;
  logic        m_busy = 0, m_rsf = 0;

  always #10 clk = ~clk;

  evt_irq_unit u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .rx_data_acc_i(rxacc), .tx_data_acc_i(txacc),
    .bus_busy_i(busy), .rx_shift_full_i(rsf), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [2:0] f_vec(logic [6:0] f, logic [6:0] m);
    logic [2:0] c = 3'd0;
    for (int i = 6; i >= 0; i--) if (f[i] & m[i]) c = 3'(i + 1);
    return c;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    evt = '0; rxacc = 0; txacc = 0; wr = 0; rd = 0; wdata = '0;
  endtask

  // Called at a negedge with inputs already driven; returns at the next negedge.
  task automatic tick(string tag);
    logic [15:0] exp_rd;
    logic [6:0]  clr;
    logic [2:0]  c;
    c = f_vec(m_flags, m_mask);
    exp_rd = '0;
    if (addr == 8'h04)      exp_rd = {9'd0, m_mask};
    else if (addr == 8'h08) exp_rd = {3'd0, m_busy, m_rsf, 4'd0, m_flags};
    else if (addr == 8'h28) exp_rd = {13'd0, c};
    clr = '0;
    if (wr && addr == 8'h08) clr |= wdata[6:0];
    if (rd && addr == 8'h28 && c != 0 && c != 3'd4 && c != 3'd5) clr[c-1] = 1'b1;
    if (rxacc) clr[3] = 1'b1;
    if (txacc) clr[4] = 1'b1;
    @(posedge clk);
    m_flags = evt | (m_flags & ~clr);
    if (wr && addr == 8'h04) m_mask = wdata[6:0];
    m_busy = busy; m_rsf = rsf;
    @(negedge clk);
    check("R8 irq", {15'd0, irq}, {15'd0, |(m_flags & m_mask)});
    if (rd) check(tag, rdata, exp_rd);
  endtask

  task automatic do_read(logic [7:0] a, string tag);
    idle(); rd = 1; addr = a; tick(tag); idle();
  endtask

  task automatic do_write(logic [7:0] a, logic [15:0] d);
    idle(); wr = 1; addr = a; wdata = d; tick("R3 wr"); idle();
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 rdata", rdata, 16'd0);
    do_read(8'h08, "R1 status");
    do_read(8'h04, "R1 mask");

    // R2 event set, R10 mask
    evt = 7'b1000101; tick("R2"); idle();
    do_read(8'h08, "R2 status bits");
    do_write(8'h04, 16'hFFFF);
    do_read(8'h04, "R10 mask upper zero");
    // R5 priority: ARB first
    do_read(8'h28, "R5 vec arb");
    // R3 W1C of bit6, zero leaves bit2
    do_write(8'h08, 16'h0040);
    do_read(8'h08, "R3 status after w1c");
    // R4 set wins
    idle(); wr = 1; addr = 8'h08; wdata = 16'h0004; evt = 7'b0000100; tick("R4"); idle();
    do_read(8'h08, "R4 flag kept");
    // R6 service loop with receive ready
    evt = 7'b0001000; tick("R6"); idle();
    do_read(8'h28, "R6 vec ardy");
    do_read(8'h28, "R6 vec rxrdy");
    do_read(8'h28, "R6 rxrdy sticky");
    // R7 data access clears
    rxacc = 1; tick("R7"); idle();
    do_read(8'h28, "R7 vec empty");
    evt = 7'b0010000; tick("R7"); idle();
    txacc = 1; tick("R7"); idle();
    do_read(8'h08, "R7 txrdy cleared");
    // R9 live bits not writable
    busy = 1; rsf = 1; tick("R9"); 
    do_write(8'h08, 16'hFFFF);
    do_read(8'h08, "R9 busy rsf kept");
    busy = 0; rsf = 0;
    // R11 hold when not reading
    do_read(8'h04, "R11 prime");
    idle(); addr = 8'h08; tick("R11"); check("R11 hold", rdata, {9'd0, m_mask});
    do_read(8'h00, "R11 unmapped");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      int sel;
      string tg;
      idle();
      sel = int'($urandom_range(0, 3));
      addr = (sel == 0) ? 8'h04 : (sel == 1) ? 8'h08 : (sel == 2) ? 8'h28 : 8'h00;
      tg = (sel == 0) ? "R10 rnd" : (sel == 1) ? "R2 rnd" : (sel == 2) ? "R5 rnd" : "R11 rnd";
      if ($urandom_range(0, 3) == 0) evt = 7'($urandom);
      rd = ($urandom_range(0, 1) == 1);
      wr = ($urandom_range(0, 4) == 0);
      wdata = 16'($urandom);
      rxacc = ($urandom_range(0, 7) == 0);
      txacc = ($urandom_range(0, 7) == 0);
      busy = 1'($urandom); rsf = 1'($urandom);
      tick(tg);
    end
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule